// File: doc/BRIEF.md
# Ten-bit-address I2C slave with byte transmit

This block is the target side of an I2C link that answers only to a 10-bit address and can hand a byte back to the bus master. It watches the SCL and SDA lines, which reach it already synchronised to the system clock. It finds START, repeated START and STOP conditions. It checks the two address bytes against a compare register that host software keeps loaded. It can pull either line low, and it never drives a line high.

The host uses a small set of strobes. It can write the address-compare register, write and read a one-byte buffer, set a clock-release bit, and clear the interrupt flag. It sees a buffer-full flag, an update-address flag, the interrupt flag and the clock-release bit. After each acknowledged address byte the block raises the update-address flag and holds SCL low. It lets SCL go once software has loaded the next compare value. In a read, the block holds SCL low before each byte it sends, and it clears the release bit on its own to do so. It sends the byte after software has filled the buffer and set the release bit again.

Top module: `i2c10_slave_tx`

## Requirements
- R1: After reset, both pull outputs, buf_full_o, upd_addr_o and irq_o are 0, ckp_o is 1 and buf_rdata_o is 0.
- R2: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. A START, repeated or not, begins a new address phase. A STOP releases both lines and clears the record of a completed 10-bit match.
- R3: The first address byte is matched when its upper five bits are 11110 and its bits 2:1 (A9, A8) equal bits 2:1 of the compare register. Bit 0 is R/W. With R/W = 0, a match is acknowledged by pulling SDA low during the 9th clock.
- R4: After an acknowledged address byte in a write phase (first or second byte), upd_addr_o is set on the 9th falling edge and SCL is held low.
- R5: A write of the compare register clears upd_addr_o and releases SCL, unless the release bit is 0.
- R6: The second address byte (A7..A0, MSB first) is acknowledged when it equals all 8 bits of the compare register. From then on, data bytes written by the master are acknowledged.
- R7: When the first address byte arrives with R/W = 1 after a completed 10-bit match and a repeated START, it is acknowledged and transmit mode starts. ckp_o is cleared and SCL stays low until the host sets the release bit. With no prior match, that byte is not acknowledged.
- R8: Each acknowledged received byte (address or data) is copied into the buffer and sets buf_full_o. A buffer read strobe clears buf_full_o.
- R9: irq_o is set on the 9th falling edge of every acknowledged byte, whether received or sent. flag_clr_i clears it.
- R10: In transmit mode, a buffer write sets buf_full_o. The byte is sent MSB first, with a 0 bit as SDA pulled low. buf_full_o clears when the 8th bit ends. A master ACK clears ckp_o again and holds SCL.
- R11: A master NACK of a sent byte makes the slave release both lines without stretching. It then ignores the bus until the next START.
- R12: A mismatch on either address byte is not acknowledged. Every later byte until the next START is also not acknowledged, and no flag is set by them.
- R13: The pull outputs are pull-low enables only. The slave begins pulling SDA low only while SCL is low, and it releases SDA during the master's acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL line level |
| sda_i | input | 1 | Synchronised SDA line level |
| scl_pull_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| adr_wr_i | input | 1 | Strobe: load compare register |
| adr_wdata_i | input | 8 | Compare register write data |
| buf_wr_i | input | 1 | Strobe: load buffer |
| buf_wdata_i | input | 8 | Buffer write data |
| buf_rd_i | input | 1 | Strobe: buffer read (clears buf_full_o) |
| buf_rdata_o | output | 8 | Buffer contents |
| rel_set_i | input | 1 | Strobe: set clock-release bit |
| flag_clr_i | input | 1 | Strobe: clear interrupt flag |
| buf_full_o | output | 1 | Buffer-full flag |
| upd_addr_o | output | 1 | Compare register needs updating |
| irq_o | output | 1 | Interrupt flag |
| ckp_o | output | 1 | Clock-release bit |

## Verification
A wrong state or a stale bit count shows up in the ACK slot of the very next byte: the master sees an ACK where a NACK is due, or the reverse. A wrong stretch decision shows up as SCL that either never releases, so the master stalls on its next rising edge, or that is not held after an address byte, visible within a few clocks of the 9th falling edge. Errors in the transmit shifter appear as wrong bits in the byte the master reads back. Flag faults are visible on the status outputs within two clocks of the strobe or the bus edge that should move them.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 2);
  localparam logic [4:0] TEN_TAG = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADR_HI,
    ST_ADR_LO,
    ST_RX,
    ST_TX
  } slv_state_t;

  // First address byte: fixed tag plus A9..A8; R/W bit is not compared.
  function automatic logic hi_byte_match(input logic [BYTE_W-1:0] rx,
                                         input logic [BYTE_W-1:0] cmp);
    return (rx[7:3] == TEN_TAG) && (rx[2:1] == cmp[2:1]);
  endfunction

  // Second address byte: all eight bits compared.
  function automatic logic lo_byte_match(input logic [BYTE_W-1:0] rx,
                                         input logic [BYTE_W-1:0] cmp);
    return rx == cmp;
  endfunction
endpackage

// File: rtl/i2c10_bus_events.sv
module i2c10_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c10_bit_timer.sv
module i2c10_bit_timer
  import i2c10_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              restart_i,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              byte_fall_o,
  output logic              ack_fall_o,
  output logic              ack_low_o
);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_C  = CNT_W'(BYTE_W + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_o <= '0;
      rx_byte_o <= '0;
      ack_low_o <= 1'b0;
    end else if (restart_i) begin
      bit_cnt_o <= '0;
    end else if (scl_rise_i && bit_cnt_o <= LAST_C) begin
      if (bit_cnt_o < LAST_C) rx_byte_o <= {rx_byte_o[BYTE_W-2:0], sda_i};
      else                    ack_low_o <= ~sda_i;
      bit_cnt_o <= bit_cnt_o + 1'b1;
    end else if (scl_fall_i && bit_cnt_o == ACK_C) begin
      bit_cnt_o <= '0;
    end
  end

  assign byte_fall_o = scl_fall_i && (bit_cnt_o == LAST_C);
  assign ack_fall_o  = scl_fall_i && (bit_cnt_o == ACK_C);
endmodule

// File: rtl/i2c10_host_regs.sv
module i2c10_host_regs
  import i2c10_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adr_wr_i,
  input  logic [BYTE_W-1:0] adr_wdata_i,
  input  logic              buf_wr_i,
  input  logic [BYTE_W-1:0] buf_wdata_i,
  input  logic              buf_rd_i,
  input  logic              rel_set_i,
  input  logic              flag_clr_i,
  input  logic              rx_copy_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              tx_done_i,
  input  logic              ua_set_i,
  input  logic              ckp_clr_i,
  input  logic              irq_set_i,
  output logic [BYTE_W-1:0] adr_q,
  output logic [BYTE_W-1:0] buf_q,
  output logic              bf_q,
  output logic              ua_q,
  output logic              ckp_q,
  output logic              irq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adr_q <= '0;
      buf_q <= '0;
      bf_q  <= 1'b0;
      ua_q  <= 1'b0;
      ckp_q <= 1'b1;
      irq_q <= 1'b0;
    end else begin
      if (adr_wr_i) adr_q <= adr_wdata_i;

      if (rx_copy_i)     buf_q <= rx_byte_i;
      else if (buf_wr_i) buf_q <= buf_wdata_i;

      if (rx_copy_i || buf_wr_i)      bf_q <= 1'b1;
      else if (buf_rd_i || tx_done_i) bf_q <= 1'b0;

      if (ua_set_i)      ua_q <= 1'b1;
      else if (adr_wr_i) ua_q <= 1'b0;

      if (ckp_clr_i)      ckp_q <= 1'b0;
      else if (rel_set_i) ckp_q <= 1'b1;

      if (irq_set_i)       irq_q <= 1'b1;
      else if (flag_clr_i) irq_q <= 1'b0;
    end
  end

  assert_bf_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd_i && !rx_copy_i && !buf_wr_i) |=> !bf_q);

  assert_adr_wr_clears_ua_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_wr_i && !ua_set_i) |=> !ua_q);

  assert_irq_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set_i |=> irq_q);

  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !irq_set_i) |=> !irq_q);
endmodule

// File: rtl/i2c10_slave_tx.sv
module i2c10_slave_tx
  import i2c10_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  input  logic              adr_wr_i,
  input  logic [BYTE_W-1:0] adr_wdata_i,
  input  logic              buf_wr_i,
  input  logic [BYTE_W-1:0] buf_wdata_i,
  input  logic              buf_rd_i,
  output logic [BYTE_W-1:0] buf_rdata_o,
  input  logic              rel_set_i,
  input  logic              flag_clr_i,
  output logic              buf_full_o,
  output logic              upd_addr_o,
  output logic              irq_o,
  output logic              ckp_o
);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(BYTE_W);

  // Bus events, brought out as named wires
  logic scl_rise, scl_fall, start_evt, stop_evt;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_byte, adr_q;
  logic byte_fall, ack_fall, ack_low;

  // Decisions and flag events
  slv_state_t state, next_after_ack;
  logic ten_ok, ack_drv, hold_q, tx_win;
  logic [BYTE_W-1:0] tx_sh;
  logic acc_hi, acc_lo, byte_ack;
  logic rx_copy, irq_set, ua_set, ckp_clr, hold_set, tx_done, addr_fail, lo_done;
  logic tx_drv;

  i2c10_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  i2c10_bit_timer u_timer (
    .clk(clk), .rst_n(rst_n), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_i(sda_i), .restart_i(start_evt | stop_evt),
    .bit_cnt_o(bit_cnt), .rx_byte_o(rx_byte),
    .byte_fall_o(byte_fall), .ack_fall_o(ack_fall), .ack_low_o(ack_low)
  );

  i2c10_host_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .adr_wr_i(adr_wr_i), .adr_wdata_i(adr_wdata_i),
    .buf_wr_i(buf_wr_i), .buf_wdata_i(buf_wdata_i), .buf_rd_i(buf_rd_i),
    .rel_set_i(rel_set_i), .flag_clr_i(flag_clr_i),
    .rx_copy_i(rx_copy), .rx_byte_i(rx_byte), .tx_done_i(tx_done),
    .ua_set_i(ua_set), .ckp_clr_i(ckp_clr), .irq_set_i(irq_set),
    .adr_q(adr_q), .buf_q(buf_rdata_o), .bf_q(buf_full_o),
    .ua_q(upd_addr_o), .ckp_q(ckp_o), .irq_q(irq_o)
  );

  // Address acceptance
  assign acc_hi = hi_byte_match(rx_byte, adr_q) && (!rx_byte[0] || ten_ok);
  assign acc_lo = lo_byte_match(rx_byte, adr_q);

  always_comb begin
    case (state)
      ST_ADR_HI: byte_ack = acc_hi;
      ST_ADR_LO: byte_ack = acc_lo;
      ST_RX:     byte_ack = 1'b1;
      default:   byte_ack = 1'b0;
    endcase
  end

  always_comb begin
    case (state)
      ST_ADR_HI: next_after_ack = !ack_drv ? ST_IDLE : (rx_byte[0] ? ST_TX : ST_ADR_LO);
      ST_ADR_LO: next_after_ack = ack_drv ? ST_RX : ST_IDLE;
      ST_RX:     next_after_ack = ST_RX;
      ST_TX:     next_after_ack = ack_low ? ST_TX : ST_IDLE;
      default:   next_after_ack = ST_IDLE;
    endcase
  end

  // Events at the 9th falling edge
  assign rx_copy   = ack_fall && ack_drv &&
                     (state == ST_ADR_HI || state == ST_ADR_LO || state == ST_RX);
  assign irq_set   = rx_copy || (ack_fall && state == ST_TX && ack_low);
  assign ua_set    = ack_fall && ack_drv &&
                     ((state == ST_ADR_HI && !rx_byte[0]) || state == ST_ADR_LO);
  assign ckp_clr   = ack_fall && ((state == ST_ADR_HI && ack_drv && rx_byte[0]) ||
                                  (state == ST_TX && ack_low));
  assign hold_set  = ua_set || ckp_clr;
  assign tx_done   = byte_fall && state == ST_TX;
  assign addr_fail = ack_fall && !ack_drv && (state == ST_ADR_HI || state == ST_ADR_LO);
  assign lo_done   = ack_fall && ack_drv && state == ST_ADR_LO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ten_ok  <= 1'b0;
      ack_drv <= 1'b0;
      hold_q  <= 1'b0;
      tx_win  <= 1'b0;
    end else if (stop_evt) begin
      state   <= ST_IDLE;
      ten_ok  <= 1'b0;
      ack_drv <= 1'b0;
      hold_q  <= 1'b0;
      tx_win  <= 1'b0;
    end else if (start_evt) begin
      state   <= ST_ADR_HI;
      ack_drv <= 1'b0;
      hold_q  <= 1'b0;
      tx_win  <= 1'b0;
    end else begin
      if (byte_fall) begin
        ack_drv <= byte_ack;
        if (state == ST_TX) tx_win <= 1'b1;
      end
      if (ack_fall) begin
        ack_drv <= 1'b0;
        tx_win  <= 1'b0;
        state   <= next_after_ack;
        if (addr_fail) ten_ok <= 1'b0;
        if (lo_done)   ten_ok <= 1'b1;
      end
      if (hold_set)                              hold_q <= 1'b1;
      else if (hold_q && !upd_addr_o && ckp_o)   hold_q <= 1'b0;
    end
  end

  // Transmit shifter: loaded by the host between bytes, shifted on SCL falls
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '1;
    end else if (buf_wr_i && !(state == ST_TX && bit_cnt != '0)) begin
      tx_sh <= buf_wdata_i;
    end else if (state == ST_TX && scl_fall && bit_cnt < LAST_C) begin
      tx_sh <= {tx_sh[BYTE_W-2:0], 1'b1};
    end
  end

  assign tx_drv     = (state == ST_TX) && !tx_win && !tx_sh[BYTE_W-1];
  assign sda_pull_o = ack_drv | tx_drv;
  assign scl_pull_o = hold_q;

  // Assertions
  assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!sda_pull_o && !scl_pull_o));

  assert_hi_mismatch_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_fall && state == ST_ADR_HI && !hi_byte_match(rx_byte, adr_q)) |=> !sda_pull_o);

  assert_ua_holds_scl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_addr_o |-> scl_pull_o);

  assert_tx_wait_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TX && !ckp_o && bit_cnt == '0 && !tx_win) |-> scl_pull_o);

  assert_tx_bf_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !buf_wr_i) |=> !buf_full_o);

  assert_nack_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fall && state == ST_TX && !ack_low) |=> (!scl_pull_o && !sda_pull_o));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (!sda_pull_o && !scl_pull_o));

  assert_sda_pull_scl_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_i);
endmodule

// File: tb/i2c10_slave_tx_tb_top.sv
module i2c10_slave_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_line, sda_line, scl_pull, sda_pull;
  logic adr_wr = 0, buf_wr = 0, buf_rd = 0, rel_set = 0, flag_clr = 0;
  logic [7:0] adr_wdata = 0, buf_wdata = 0, buf_rdata;
  logic buf_full, upd_addr, irq, ckp;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_line = m_scl & ~scl_pull;
  assign sda_line = m_sda & ~sda_pull;

  i2c10_slave_tx dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull),
    .adr_wr_i(adr_wr), .adr_wdata_i(adr_wdata),
    .buf_wr_i(buf_wr), .buf_wdata_i(buf_wdata), .buf_rd_i(buf_rd),
    .buf_rdata_o(buf_rdata), .rel_set_i(rel_set), .flag_clr_i(flag_clr),
    .buf_full_o(buf_full), .upd_addr_o(upd_addr), .irq_o(irq), .ckp_o(ckp)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_line) @(negedge clk);
  endtask

  // Master-side bus primitives
  task automatic m_start();
    m_sda = 1'b1; wait_q();
    m_scl = 1'b1; wait_scl_high(); wait_q();
    m_sda = 1'b0; wait_q();
    m_scl = 1'b0; wait_q();
  endtask

  task automatic m_stop();
    m_sda = 1'b0; wait_q();
    m_scl = 1'b1; wait_scl_high(); wait_q();
    m_sda = 1'b1; wait_q();
  endtask

  task automatic m_bit(input logic b);
    m_sda = b; wait_q();
    m_scl = 1'b1; wait_scl_high(); wait_q();
    m_scl = 1'b0; wait_q();
  endtask

  task automatic m_send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) m_bit(b[i]);
    m_sda = 1'b1; wait_q();
    m_scl = 1'b1; wait_scl_high(); wait_q();
    ack = ~sda_line;
    m_scl = 1'b0; wait_q();
  endtask

  task automatic m_read(output logic [7:0] d, input logic give_ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wait_q();
      m_scl = 1'b1; wait_scl_high(); wait_q();
      d[i] = sda_line;
      m_scl = 1'b0; wait_q();
    end
    m_sda = ~give_ack; wait_q();
    m_scl = 1'b1; wait_scl_high(); wait_q();
    chk("R13 slave releases SDA in master ack clock", sda_pull, 1'b0);
    m_scl = 1'b0; wait_q();
    m_sda = 1'b1;
  endtask

  // Host-side strobes
  task automatic h_adr(input logic [7:0] v);
    @(negedge clk); adr_wr = 1'b1; adr_wdata = v;
    @(negedge clk); adr_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic h_bufw(input logic [7:0] v);
    @(negedge clk); buf_wr = 1'b1; buf_wdata = v;
    @(negedge clk); buf_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic h_bufr(output logic [7:0] v);
    @(negedge clk); v = buf_rdata; buf_rd = 1'b1;
    @(negedge clk); buf_rd = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic h_rel();
    @(negedge clk); rel_set = 1'b1;
    @(negedge clk); rel_set = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic h_clr();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Scenarios
  task automatic t_reset();
    chk("R1 scl_pull", scl_pull, 0);
    chk("R1 sda_pull", sda_pull, 0);
    chk("R1 buf_full", buf_full, 0);
    chk("R1 upd_addr", upd_addr, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ckp", ckp, 1);
    chk("R1 buf_rdata", buf_rdata, 8'h00);
  endtask

  task automatic t_write_phase();
    logic a; logic [7:0] v;
    h_adr(8'hF4);
    m_start();
    m_send(8'hF4, a);
    chk("R3 first byte ack", a, 1);
    chk("R4 ua after first byte", upd_addr, 1);
    chk("R4 scl held after first byte", scl_pull, 1);
    chk("R9 irq after first byte", irq, 1);
    chk("R8 bf after first byte", buf_full, 1);
    h_bufr(v);
    chk("R8 buffer holds first byte", v, 8'hF4);
    chk("R8 bf cleared by read", buf_full, 0);
    h_clr();
    chk("R9 irq cleared", irq, 0);
    h_adr(8'hB5);
    chk("R5 ua cleared by write", upd_addr, 0);
    chk("R5 scl released", scl_pull, 0);
    m_send(8'hB5, a);
    chk("R6 second byte ack", a, 1);
    chk("R4 ua after second byte", upd_addr, 1);
    chk("R4 scl held after second byte", scl_pull, 1);
    h_bufr(v);
    chk("R8 buffer holds second byte", v, 8'hB5);
    h_clr();
    h_adr(8'hF4);
    m_send(8'h3C, a);
    chk("R6 data byte ack", a, 1);
    chk("R8 data byte bf", buf_full, 1);
    chk("R8 data byte no stretch", scl_pull, 0);
    h_bufr(v);
    chk("R8 data byte value", v, 8'h3C);
    h_clr();
  endtask

  task automatic t_read_phase();
    logic a; logic [7:0] d;
    m_start();
    m_send(8'hF5, a);
    chk("R7 read address ack", a, 1);
    chk("R7 ckp cleared", ckp, 0);
    chk("R7 scl held for transmit", scl_pull, 1);
    chk("R9 irq on read address", irq, 1);
    h_bufr(d);
    h_clr();
    h_bufw(8'hA6);
    chk("R10 bf set by buffer write", buf_full, 1);
    chk("R7 scl still held before release", scl_pull, 0 + 1);
    h_rel();
    m_read(d, 1'b1);
    chk("R10 first sent byte", d, 8'hA6);
    chk("R10 bf cleared after send", buf_full, 0);
    chk("R10 ckp cleared after master ack", ckp, 0);
    chk("R10 scl held after master ack", scl_pull, 1);
    chk("R9 irq after sent byte", irq, 1);
    h_clr();
    h_bufw(8'h5A);
    h_rel();
    m_read(d, 1'b0);
    chk("R10 second sent byte", d, 8'h5A);
    chk("R11 scl released after nack", scl_pull, 0);
    chk("R11 sda released after nack", sda_pull, 0);
    chk("R9 no irq on nacked byte", irq, 0);
    m_stop();
    chk("R2 stop releases scl", scl_pull, 0);
    chk("R2 stop releases sda", sda_pull, 0);
  endtask

  task automatic t_hi_mismatch();
    logic a;
    m_start();
    m_send(8'hF6, a);
    chk("R12 first byte mismatch nack", a, 0);
    m_send(8'hF4, a);
    chk("R12 later byte ignored", a, 0);
    chk("R12 no irq", irq, 0);
    chk("R12 no bf", buf_full, 0);
    chk("R12 no ua", upd_addr, 0);
    m_stop();
  endtask

  task automatic t_lo_mismatch();
    logic a; logic [7:0] v;
    m_start();
    m_send(8'hF4, a);
    chk("R3 first byte ack again", a, 1);
    h_bufr(v);
    h_clr();
    h_adr(8'hB5);
    m_send(8'hB4, a);
    chk("R12 second byte mismatch nack", a, 0);
    chk("R12 no ua after mismatch", upd_addr, 0);
    chk("R12 scl free after mismatch", scl_pull, 0);
    chk("R12 no bf after mismatch", buf_full, 0);
    m_stop();
    h_adr(8'hF4);
  endtask

  task automatic t_read_no_match();
    logic a;
    m_start();
    m_send(8'hF5, a);
    chk("R7 read address without match nack", a, 0);
    chk("R7 ckp unchanged without match", ckp, 1);
    m_stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write_phase();
    t_read_phase();
    t_hi_mismatch();
    t_lo_mismatch();
    t_read_no_match();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule